// File: doc/BRIEF.md
# Run-Mode Interrupt Flag Register

This block holds the sixteen-bit word of run-time interrupt flags for a processor core. Ten of its bits are interrupt requests. Fault, timer, parity, module, external and power-fail sources set them with single-cycle pulses. The status unit can also set the integer-overflow request through a separate overflow input. The five low bits are status flags that never request service: interrupt stack active, dispatcher active, emulator in use, I/O timeout and option present. One bit is reserved and always reads as zero. Software-style clear strobes, one per word bit, reset flags.

From the request bits the block derives three outputs, all registered: a pending indication, the six-bit service-table number of the request that wins, and a separate indication that the winner is the external interrupt. The service number of a request is its bit index counted from the most significant bit. A lower index has higher priority, so integer overflow wins over every other request.

All pins are plain control and status signals. No data stream passes through the block, so it has no valid/ready handshake and never applies back-pressure.

Top module: `runirq_flags`

## Requirements
- R1: While reset is asserted and after it is released, all sixteen flag bits read 0, and pending, service number and external indication are 0.
- R2: A pulse on `req_set_i[i]` (i = 0..9) sets word bit 15-i at the next rising edge. The index order is: 0 integer overflow, 1 bounds violation, 2 illegal address, 3 CPU timer / non-responding module, 4 system parity, 5 address parity, 6 data parity, 7 module, 8 external, 9 power fail. A pulse on `ovf_i` also sets bit 15.
- R3: A pulse on `stat_set_i[j]` sets word bit j at the next rising edge. Bit 4 is interrupt stack active, bit 3 dispatcher active, bit 2 emulator in use, bit 1 I/O timeout and bit 0 option present.
- R4: A high `clr_i[b]` clears word bit b at the next rising edge. A bit with neither a set nor a clear holds its value.
- R5: When a set and a clear reach the same bit in the same cycle, the bit is set after the edge.
- R6: Word bit 5 always reads 0, and a clear strobe on it changes nothing.
- R7: `irq_pend_o` is the OR of word bits 15..6, registered one cycle after those flags change.
- R8: `irq_num_o` is the index of the pending request with the lowest index (word bit 15-index). It is registered in the same cycle as `irq_pend_o` and is 0 when nothing is pending.
- R9: Status bits 4..0 never make `irq_pend_o` go high.
- R10: `irq_ext_o` is high, in the same cycle as `irq_pend_o`, exactly when the selected request is the external interrupt (index 8, word bit 7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_set_i | input | 10 | Request set pulses, index 0 = integer overflow |
| ovf_i | input | 1 | Overflow pulse from the status unit, sets the integer-overflow request |
| stat_set_i | input | 5 | Status-flag set pulses, aligned to word bits 4..0 |
| clr_i | input | 16 | Clear strobes, one per word bit |
| flags_o | output | 16 | Flag word |
| irq_pend_o | output | 1 | Some request is pending (registered) |
| irq_num_o | output | 6 | Service number of the selected request (registered) |
| irq_ext_o | output | 1 | Selected request is the external interrupt (registered) |

## Verification
The properties place no limit on the inputs. Sets and clears may arrive in any cycle and in any combination, so each property relates the flag word or the registered outputs to the previous cycle's inputs or flags. The stimulus changes inputs only on the falling clock edge and holds each pattern for exactly one rising edge. Every observation therefore belongs to one known edge. The sequence covers simultaneous set and clear, the reserved bit, status-only words and several priority orderings.

// File: rtl/runirq_pkg.sv
package runirq_pkg;
  // word layout
  localparam int WORD_W  = 16;
  localparam int REQ_N   = 10;   // request flags, MSB-first index 0..REQ_N-1
  localparam int STAT_N  = 5;    // status flags at the bottom of the word
  localparam int NUM_W   = 6;    // service-number width
  localparam int EXT_IDX = 8;    // external interrupt request index
  localparam int RSV_N   = WORD_W - REQ_N - STAT_N;

  // word bit that holds a request index
  function automatic int req_bit(input int idx);
    return WORD_W - 1 - idx;
  endfunction
endpackage

// File: rtl/runirq_bank.sv
// A bank of set/clear flag cells; a set beats a clear on the same bit.
module runirq_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar k = 0; k < N; k++) begin : g_cell
    logic bit_q;
    always_ff @(posedge clk) begin
      if (!rst_n)         bit_q <= 1'b0;
      else if (set_i[k])  bit_q <= 1'b1;
      else if (clr_i[k])  bit_q <= 1'b0;
    end
    assign q_o[k] = bit_q;
  end
endmodule

// File: rtl/runirq_prio.sv
// Picks the lowest index among active requests (index 0 wins).
module runirq_prio #(
  parameter int N     = 10,
  parameter int NUM_W = 6
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [NUM_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = NUM_W'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/runirq_flags.sv
module runirq_flags
  import runirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REQ_N-1:0]  req_set_i,
  input  logic              ovf_i,
  input  logic [STAT_N-1:0] stat_set_i,
  input  logic [WORD_W-1:0] clr_i,
  output logic [WORD_W-1:0] flags_o,
  output logic              irq_pend_o,
  output logic [NUM_W-1:0]  irq_num_o,
  output logic              irq_ext_o
);
  localparam int RSV_LO = STAT_N;

  logic [REQ_N-1:0]  req_set, req_clr, req_q;
  logic [STAT_N-1:0] stat_q;
  logic              sel_any;
  logic [NUM_W-1:0]  sel_idx;

  // request index i lives at word bit WORD_W-1-i
  for (genvar i = 0; i < REQ_N; i++) begin : g_req_map
    if (i == 0) begin : g_ovf
      assign req_set[i] = req_set_i[i] | ovf_i;
    end else begin : g_plain
      assign req_set[i] = req_set_i[i];
    end
    assign req_clr[i]              = clr_i[req_bit(i)];
    assign flags_o[req_bit(i)]     = req_q[i];
  end

  runirq_bank #(.N(REQ_N)) u_req_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (req_set),
    .clr_i (req_clr),
    .q_o   (req_q)
  );

  runirq_bank #(.N(STAT_N)) u_stat_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (stat_set_i),
    .clr_i (clr_i[STAT_N-1:0]),
    .q_o   (stat_q)
  );
  assign flags_o[STAT_N-1:0] = stat_q;

  // reserved bits carry no storage; their strobes act on nothing
  for (genvar r = 0; r < RSV_N; r++) begin : g_rsv
    assign flags_o[RSV_LO + r] = clr_i[RSV_LO + r] & 1'b0;
  end

  runirq_prio #(.N(REQ_N), .NUM_W(NUM_W)) u_prio (
    .req_i (req_q),
    .any_o (sel_any),
    .idx_o (sel_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_pend_o <= 1'b0;
      irq_num_o  <= '0;
      irq_ext_o  <= 1'b0;
    end else begin
      irq_pend_o <= sel_any;
      irq_num_o  <= sel_idx;
      irq_ext_o  <= sel_any && (sel_idx == NUM_W'(EXT_IDX));
    end
  end
endmodule

// File: rtl/runirq_flags_chk.sv
module runirq_flags_chk
  import runirq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [REQ_N-1:0]  req_set_i,
  input logic              ovf_i,
  input logic [STAT_N-1:0] stat_set_i,
  input logic [WORD_W-1:0] clr_i,
  input logic [WORD_W-1:0] flags_o,
  input logic              irq_pend_o,
  input logic [NUM_W-1:0]  irq_num_o,
  input logic              irq_ext_o
);
  AST_OVF_SETS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_i |=> flags_o[WORD_W-1]); // R2

  AST_TIMER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    req_set_i[3] |=> flags_o[12]); // R2

  AST_STAT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_set_i[4] |=> flags_o[4]); // R3

  AST_CLEAR_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i[WORD_W-1] && !req_set_i[0] && !ovf_i) |=> !flags_o[WORD_W-1]); // R4

  AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_set_i[8] && clr_i[7]) |=> flags_o[7]); // R5

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    flags_o[5] == 1'b0); // R6

  AST_PEND_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_pend_o == $past(|flags_o[WORD_W-1:STAT_N+RSV_N]))); // R7

  AST_NUM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pend_o |-> (irq_num_o < NUM_W'(REQ_N))); // R8

  AST_TOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    flags_o[WORD_W-1] |=> (irq_num_o == '0)); // R8

  AST_STATUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o[WORD_W-1:STAT_N+RSV_N] == '0) |=> !irq_pend_o); // R9

  AST_EXT_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ext_o |-> (irq_pend_o && irq_num_o == NUM_W'(EXT_IDX))); // R10
endmodule

bind runirq_flags runirq_flags_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_set_i  (req_set_i),
  .ovf_i      (ovf_i),
  .stat_set_i (stat_set_i),
  .clr_i      (clr_i),
  .flags_o    (flags_o),
  .irq_pend_o (irq_pend_o),
  .irq_num_o  (irq_num_o),
  .irq_ext_o  (irq_ext_o)
);

// File: tb/tb_runirq_flags.sv
`timescale 1ns/1ps
module tb_runirq_flags;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  req_set_i = '0;
  logic        ovf_i = 1'b0;
  logic [4:0]  stat_set_i = '0;
  logic [15:0] clr_i = '0;
  logic [15:0] flags_o;
  logic        irq_pend_o;
  logic [5:0]  irq_num_o;
  logic        irq_ext_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk; // 125 MHz

  runirq_flags dut (
    .clk(clk), .rst_n(rst_n), .req_set_i(req_set_i), .ovf_i(ovf_i),
    .stat_set_i(stat_set_i), .clr_i(clr_i), .flags_o(flags_o),
    .irq_pend_o(irq_pend_o), .irq_num_o(irq_num_o), .irq_ext_o(irq_ext_o));

  typedef struct {
    logic [15:0] flags;
    logic        pend;
    logic [5:0]  num;
    logic        ext;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  logic [15:0] model = '0;

  function automatic logic [5:0] pick(input logic [15:0] w);
    for (int i = 0; i < 10; i++) if (w[15-i]) return 6'(i);
    return 6'd0;
  endfunction

  // driver: apply one cycle of stimulus, push what the outputs must show after it
  task automatic step(input logic [9:0] rs, input logic ov, input logic [4:0] ss,
                      input logic [15:0] cl, input string tag);
    logic [15:0] setw;
    exp_t e;
    req_set_i = rs; ovf_i = ov; stat_set_i = ss; clr_i = cl;
    setw = '0;
    for (int i = 0; i < 10; i++) if (rs[i]) setw[15-i] = 1'b1;
    if (ov) setw[15] = 1'b1;
    setw[4:0] = ss;
    e.pend  = |model[15:6];
    e.num   = e.pend ? pick(model) : 6'd0;
    e.ext   = e.pend && (pick(model) == 6'd8);
    model   = (model & ~cl) | setw;
    model[5] = 1'b0;
    e.flags = model;
    e.tag   = tag;
    @(posedge clk);
    sb_q.push_back(e);
    @(negedge clk);
    req_set_i = '0; ovf_i = 1'b0; stat_set_i = '0; clr_i = '0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (flags_o !== e.flags || irq_pend_o !== e.pend ||
          irq_num_o !== e.num || irq_ext_o !== e.ext) begin
        failures++;
        $display("FAIL %s: got flags=%h pend=%b num=%0d ext=%b exp flags=%h pend=%b num=%0d ext=%b",
                 e.tag, flags_o, irq_pend_o, irq_num_o, irq_ext_o,
                 e.flags, e.pend, e.num, e.ext);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (flags_o !== 16'h0 || irq_pend_o !== 1'b0 || irq_num_o !== 6'd0 || irq_ext_o !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset: got flags=%h pend=%b num=%0d ext=%b exp all zero",
               flags_o, irq_pend_o, irq_num_o, irq_ext_o);
    end
    rst_n = 1'b1;
    @(negedge clk);
    step(10'b0000000001, 0, 0, 0,        "R2 integer overflow set");
    step(0, 0, 0, 0,                      "R7 R8 pending index 0");
    step(10'b1000001000, 0, 0, 0,        "R2 timer and power fail set");
    step(0, 0, 0, 16'h8000,               "R4 clear top bit");
    step(0, 0, 0, 0,                      "R8 timer wins number 3");
    step(0, 1, 0, 0,                      "R2 overflow input sets top bit");
    step(0, 0, 0, 0,                      "R8 overflow again wins");
    step(0, 0, 0, 16'h9040,               "R4 clear all requests");
    step(0, 0, 0, 0,                      "R7 pending drops");
    step(10'b0100000000, 0, 0, 0,        "R2 external set");
    step(0, 0, 0, 0,                      "R10 external marked");
    step(10'b0100000000, 0, 0, 16'h0080, "R5 set beats clear");
    step(0, 0, 0, 16'hFFFF,               "R4 clear whole word");
    step(0, 0, 5'b11111, 0,               "R3 status flags set");
    step(0, 0, 0, 0,                      "R9 status raises no request");
    step(0, 0, 0, 16'h0020,               "R6 reserved strobe no effect");
    step(0, 0, 0, 16'h0008,               "R4 clear dispatcher flag");
    step(10'b0001000010, 0, 0, 0,        "R2 bounds and data parity");
    step(0, 0, 0, 0,                      "R8 bounds wins number 1");
    step(0, 0, 0, 0,                      "R8 steady");
    repeat (2) @(negedge clk);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout exp completion");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule